// File: doc/BRIEF.md
# Pause-Width Frame Transmitter

This block sends reader-to-card frames over an amplitude-keyed carrier. A bit's value is carried only by its total length. Every bit opens with a short, fixed carrier-off pause. The carrier then comes back on until the bit slot closes, and the slot is longer for a one than for a zero. A caller hands in a frame word, a bit count and the end-of-last-frame timestamp. The block waits a fixed gap after that timestamp and then sends the bits, least significant first. It ends the frame with one extra pause and returns the timestamp at which that pause ended. The next receive or transmit step starts from that returned timestamp.

Each bit is masked with one keystream bit from an external generator before it goes on air. The block pulses a strobe once per bit so that the generator steps. All deadlines are computed from a free-running tick counter supplied from outside. Each deadline is the previous deadline plus a fixed step, never the time at which a step actually finished, so slot boundaries do not accumulate error. The deadline compare uses the sign of the difference, so it keeps working when the counter wraps.

Top module: `pause_width_tx`

## Requirements
- R1: After reset, `pause_out`, `busy`, `done` and `ks_adv` are all 0, and `pause_out` is 0 whenever `busy` is 0.
- R2: The first pause of a frame begins when `now_ts` reaches `ts_in + GAP_TICKS` (330 by default), where `ts_in` is taken with the accepted `start` pulse.
- R3: Each bit begins with a pause (`pause_out` = 1) of `PAUSE_TICKS` (30). The carrier then stays on until the bit slot has lasted `ONE_TICKS` (150) in total for an on-air 1, or `ZERO_TICKS` (90) for an on-air 0. The next slot starts right at the end of the previous one.
- R4: The on-air value of bit i is `frame[i] ^ ks_bit`, sampled at the first cycle of that bit's pause. Bit 0 is sent first.
- R5: `ks_adv` is a one-cycle pulse that rises together with each bit's pause. A frame produces exactly as many pulses as it has bits.
- R6: After the last bit, a closing pause of `PAUSE_TICKS` is sent. When it ends, `pause_out` returns to 0, `done` pulses for one cycle, `busy` falls, and `ts_out` holds the tick value at which the closing pause ended.
- R7: `ts_out` is held stable while a frame is in flight. A frame started with `ts_in` equal to a previous `ts_out` has its first pause exactly `GAP_TICKS` after that value.
- R8: A `start` pulse arriving while `busy` is 1 has no effect on the frame in progress and does not queue another frame.
- R9: A length of 0 sends only the gap and the closing pause, with no `ks_adv` pulse.
- R10: A length above `FRAME_W` (32) is treated as `FRAME_W`.
- R11: Deadline comparisons use modulo-2^TS_W arithmetic, so frames that cross the wrap of `now_ts` keep exact timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| now_ts | input | TS_W | Free-running tick counter (time base) |
| start | input | 1 | Begin a frame; honoured only when idle |
| frame | input | FRAME_W | Frame word, bit 0 sent first |
| len | input | LEN_W | Number of bits to send |
| ts_in | input | TS_W | End timestamp of the previous frame |
| ks_bit | input | 1 | Current keystream bit |
| ks_adv | output | 1 | Step the keystream generator |
| pause_out | output | 1 | 1 = carrier off |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle pulse at the end of a frame |
| ts_out | output | TS_W | End timestamp of the last frame |

## Verification
The bench builds the block with a 16-bit time base and starts the tick counter just below its wrap point. Chained frames therefore run across the rollover, which exercises the sign-based deadline compare under R11. The frame width and tick lengths stay at their defaults, so lengths 0, 1, 5, 8, 32 and 40 cover both the empty frame and the clamping case. One tick equals one clock, so every expected pause edge lands on an exact clock cycle. Keystream masking is exercised by a generator model that changes which bits are long and which are short.

// File: rtl/pwtx_pkg.sv
package pwtx_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_GAP   = 3'd1,
      ST_PAUSE = 3'd2,
      ST_MARK  = 3'd3,
      ST_TAIL  = 3'd4
   } pwtx_state_t;

endpackage

// File: rtl/pwtx_deadline.sv
// Running deadline register with a wrap-safe "time reached" compare.
module pwtx_deadline #(
   parameter int TS_W = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [TS_W-1:0] load_ts,
   input  logic            adv,
   input  logic [TS_W-1:0] adv_ticks,
   input  logic [TS_W-1:0] now_ts,
   output logic [TS_W-1:0] deadline,
   output logic            reached
);
   logic [TS_W-1:0] diff;

   always_ff @(posedge clk) begin
      if (!rst_n)
         deadline <= '0;
      else if (load)
         deadline <= load_ts;
      else if (adv)
         deadline <= deadline + adv_ticks;
   end

   // now - deadline, read as signed: non-negative means the deadline is due
   assign diff    = now_ts - deadline;
   assign reached = ~diff[TS_W-1];
endmodule

// File: rtl/pwtx_shifter.sv
// Frame holding register; presents the next bit to send.
module pwtx_shifter #(
   parameter int FRAME_W   = 32,
   parameter bit LSB_FIRST = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [FRAME_W-1:0] frame,
   input  logic               shift,
   output logic               cur_bit
);
   logic [FRAME_W-1:0] sr;

   generate
      if (LSB_FIRST) begin : g_lsb
         always_ff @(posedge clk) begin
            if (!rst_n)     sr <= '0;
            else if (load)  sr <= frame;
            else if (shift) sr <= {1'b0, sr[FRAME_W-1:1]};
         end
         assign cur_bit = sr[0];
      end else begin : g_msb
         always_ff @(posedge clk) begin
            if (!rst_n)     sr <= '0;
            else if (load)  sr <= frame;
            else if (shift) sr <= {sr[FRAME_W-2:0], 1'b0};
         end
         assign cur_bit = sr[FRAME_W-1];
      end
   endgenerate
endmodule

// File: rtl/pwtx_ctrl.sv
// Frame sequencer: gap, per-bit pause/mark slots, closing pause.
module pwtx_ctrl
   import pwtx_pkg::*;
#(
   parameter int TS_W        = 32,
   parameter int LEN_W       = 6,
   parameter int PAUSE_TICKS = 30,
   parameter int ZERO_TICKS  = 90,
   parameter int ONE_TICKS   = 150
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [LEN_W-1:0] len_eff,
   input  logic             reached,
   input  logic             cur_bit,
   input  logic             ks_bit,
   input  logic [TS_W-1:0]  deadline,
   output logic             dl_load,
   output logic             dl_adv,
   output logic [TS_W-1:0]  dl_step,
   output logic             sh_load,
   output logic             sh_shift,
   output logic             pause_out,
   output logic             busy,
   output logic             done,
   output logic             ks_adv,
   output logic [TS_W-1:0]  ts_out
);
   localparam logic [TS_W-1:0] STEP_PAUSE = TS_W'(PAUSE_TICKS);
   localparam logic [TS_W-1:0] STEP_MARK1 = TS_W'(ONE_TICKS - PAUSE_TICKS);
   localparam logic [TS_W-1:0] STEP_MARK0 = TS_W'(ZERO_TICKS - PAUSE_TICKS);

   pwtx_state_t      state_q, state_d;
   logic [LEN_W-1:0] cnt_q, len_q;
   logic             air_q;
   logic             begin_bit, enter_tail, carrier_on, finish;

   always_comb begin
      state_d    = state_q;
      dl_load    = 1'b0;
      dl_adv     = 1'b0;
      dl_step    = STEP_PAUSE;
      sh_load    = 1'b0;
      sh_shift   = 1'b0;
      begin_bit  = 1'b0;
      enter_tail = 1'b0;
      carrier_on = 1'b0;
      finish     = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (start) begin
               dl_load = 1'b1;
               sh_load = 1'b1;
               state_d = ST_GAP;
            end
         end
         ST_GAP, ST_MARK: begin
            if (reached) begin
               dl_adv = 1'b1;
               if (cnt_q == len_q) begin
                  enter_tail = 1'b1;
                  state_d    = ST_TAIL;
               end else begin
                  begin_bit = 1'b1;
                  sh_shift  = 1'b1;
                  state_d   = ST_PAUSE;
               end
            end
         end
         ST_PAUSE: begin
            if (reached) begin
               dl_adv     = 1'b1;
               dl_step    = air_q ? STEP_MARK1 : STEP_MARK0;
               carrier_on = 1'b1;
               state_d    = ST_MARK;
            end
         end
         ST_TAIL: begin
            if (reached) begin
               finish  = 1'b1;
               state_d = ST_IDLE;
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         cnt_q     <= '0;
         len_q     <= '0;
         air_q     <= 1'b0;
         pause_out <= 1'b0;
         done      <= 1'b0;
         ks_adv    <= 1'b0;
         ts_out    <= '0;
      end else begin
         state_q <= state_d;
         ks_adv  <= begin_bit;
         done    <= finish;
         if (sh_load) begin
            cnt_q <= '0;
            len_q <= len_eff;
         end
         if (begin_bit) begin
            air_q <= cur_bit ^ ks_bit;
            cnt_q <= cnt_q + 1'b1;
         end
         if (begin_bit || enter_tail)
            pause_out <= 1'b1;
         else if (carrier_on || finish)
            pause_out <= 1'b0;
         if (finish)
            ts_out <= deadline;
      end
   end

   assign busy = (state_q != ST_IDLE);
endmodule

// File: rtl/pause_width_tx.sv
// Pause-width encoded frame transmitter (top).
module pause_width_tx #(
   parameter int FRAME_W     = 32,
   parameter int TS_W        = 32,
   parameter int PAUSE_TICKS = 30,
   parameter int ZERO_TICKS  = 90,
   parameter int ONE_TICKS   = 150,
   parameter int GAP_TICKS   = 330,
   parameter bit LSB_FIRST   = 1'b1,
   parameter int LEN_W       = $clog2(FRAME_W + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [TS_W-1:0]    now_ts,
   input  logic               start,
   input  logic [FRAME_W-1:0] frame,
   input  logic [LEN_W-1:0]   len,
   input  logic [TS_W-1:0]    ts_in,
   input  logic               ks_bit,
   output logic               ks_adv,
   output logic               pause_out,
   output logic               busy,
   output logic               done,
   output logic [TS_W-1:0]    ts_out
);
   localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(FRAME_W);
   localparam logic [TS_W-1:0]  GAP_TS  = TS_W'(GAP_TICKS);

   generate
      if (PAUSE_TICKS < 1 || ZERO_TICKS <= PAUSE_TICKS || ONE_TICKS <= ZERO_TICKS) begin : g_bad_timing
         $error("pause_width_tx: need 0 < PAUSE_TICKS < ZERO_TICKS < ONE_TICKS");
      end
      if (FRAME_W < 2 || TS_W < 8) begin : g_bad_width
         $error("pause_width_tx: FRAME_W must be >= 2 and TS_W >= 8");
      end
      if (LEN_W < $clog2(FRAME_W + 1)) begin : g_bad_len
         $error("pause_width_tx: LEN_W too narrow for FRAME_W");
      end
   endgenerate

   logic [LEN_W-1:0] len_eff;
   logic [TS_W-1:0]  dl_step, deadline;
   logic             dl_load, dl_adv, sh_load, sh_shift, reached, cur_bit;

   assign len_eff = (len > LEN_MAX) ? LEN_MAX : len;

   pwtx_deadline #(.TS_W(TS_W)) u_deadline (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (dl_load),
      .load_ts  (ts_in + GAP_TS),
      .adv      (dl_adv),
      .adv_ticks(dl_step),
      .now_ts   (now_ts),
      .deadline (deadline),
      .reached  (reached)
   );

   pwtx_shifter #(.FRAME_W(FRAME_W), .LSB_FIRST(LSB_FIRST)) u_shifter (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (sh_load),
      .frame  (frame),
      .shift  (sh_shift),
      .cur_bit(cur_bit)
   );

   pwtx_ctrl #(
      .TS_W       (TS_W),
      .LEN_W      (LEN_W),
      .PAUSE_TICKS(PAUSE_TICKS),
      .ZERO_TICKS (ZERO_TICKS),
      .ONE_TICKS  (ONE_TICKS)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .len_eff  (len_eff),
      .reached  (reached),
      .cur_bit  (cur_bit),
      .ks_bit   (ks_bit),
      .deadline (deadline),
      .dl_load  (dl_load),
      .dl_adv   (dl_adv),
      .dl_step  (dl_step),
      .sh_load  (sh_load),
      .sh_shift (sh_shift),
      .pause_out(pause_out),
      .busy     (busy),
      .done     (done),
      .ks_adv   (ks_adv),
      .ts_out   (ts_out)
   );
endmodule

// File: rtl/pause_width_tx_chk.sv
// Property checker attached to every pause_width_tx instance.
module pause_width_tx_chk #(
   parameter int TS_W = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic            start,
   input logic            pause_out,
   input logic            busy,
   input logic            done,
   input logic            ks_adv,
   input logic [TS_W-1:0] ts_out
);
   assert_idle_carrier_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !pause_out);

   assert_adv_with_pause_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ks_adv |-> $rose(pause_out));

   assert_done_ends_pause_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($fell(pause_out) && !busy && $past(busy)));

   assert_ts_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> $stable(ts_out));

   assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && !done) |=> (busy || done));
endmodule

bind pause_width_tx pause_width_tx_chk #(.TS_W(TS_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .pause_out(pause_out),
   .busy     (busy),
   .done     (done),
   .ks_adv   (ks_adv),
   .ts_out   (ts_out)
);

// File: tb/pause_width_tx_test.sv
`timescale 1ns/1ps
module pause_width_tx_test;
   localparam int TS_W  = 16;
   localparam int FW    = 32;
   localparam int LW    = 6;
   localparam logic [TS_W-1:0] T_START = 16'hF800;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [TS_W-1:0] tnow;
   logic            start = 1'b0;
   logic [FW-1:0]   frame = '0;
   logic [LW-1:0]   len = '0;
   logic [TS_W-1:0] ts_in = '0;
   logic [15:0]     ks;
   logic            ks_adv, pause_out, busy, done;
   logic [TS_W-1:0] ts_out;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   int adv_cnt = 0;
   logic prev_pause = 1'b0;

   logic [TS_W-1:0] q_t[$];
   logic            q_lvl[$];
   int              q_tag[$];
   logic [TS_W-1:0] q_done_ts[$];
   int              q_adv[$];

   always #2.5 clk = ~clk;

   always @(posedge clk) begin
      if (!rst_n) tnow <= T_START;
      else        tnow <= tnow + 1'b1;
   end

   function automatic logic [15:0] lfsr(input logic [15:0] x);
      return (x >> 1) ^ (x[0] ? 16'hB400 : 16'h0000);
   endfunction

   always @(posedge clk) begin
      if (!rst_n)      ks <= 16'hACE1;
      else if (ks_adv) ks <= lfsr(ks);
   end

   pause_width_tx #(.FRAME_W(FW), .TS_W(TS_W)) uut (
      .clk(clk), .rst_n(rst_n), .now_ts(tnow), .start(start), .frame(frame),
      .len(len), .ts_in(ts_in), .ks_bit(ks[0]), .ks_adv(ks_adv),
      .pause_out(pause_out), .busy(busy), .done(done), .ts_out(ts_out)
   );

   // Monitor: pops expected pause edges and frame ends from the scoreboard
   always @(negedge clk) begin
      if (rst_n) begin
         if (ks_adv) adv_cnt++;
         if (pause_out !== prev_pause) begin
            checks++;
            if (q_t.size() == 0) begin
               errors++;
               $display("FAIL R8 unexpected pause edge to %0b at tick %0d, expected none",
                        pause_out, tnow - 1'b1);
            end else begin
               logic [TS_W-1:0] et;
               logic el;
               int tg;
               et = q_t.pop_front();
               el = q_lvl.pop_front();
               tg = q_tag.pop_front();
               // tag 2: first pause after the gap (R2), 3: bit slots (R3/R4), 6: closing pause (R6)
               if (pause_out !== el || (tnow - 1'b1) !== et) begin
                  errors++;
                  $display("FAIL R%0d pause edge: actual level %0b at tick %0d, expected level %0b at tick %0d",
                           tg, pause_out, tnow - 1'b1, el, et);
               end
            end
            prev_pause = pause_out;
         end
         if (done) begin
            logic [TS_W-1:0] ed;
            int ea;
            checks += 3;
            ed = (q_done_ts.size() > 0) ? q_done_ts.pop_front() : '0;
            ea = (q_adv.size() > 0) ? q_adv.pop_front() : -1;
            if (ts_out !== ed || (tnow - 1'b1) !== ed) begin   // R6 / R7 / R11
               errors++;
               $display("FAIL R6 done/ts_out: actual ts_out %0d at tick %0d, expected %0d",
                        ts_out, tnow - 1'b1, ed);
            end
            if (busy !== 1'b0 || pause_out !== 1'b0) begin      // R6
               errors++;
               $display("FAIL R6 at done: actual busy %0b pause %0b, expected 0 0", busy, pause_out);
            end
            if (adv_cnt != ea) begin                             // R5 / R9 / R10
               errors++;
               $display("FAIL R5 keystream steps: actual %0d, expected %0d", adv_cnt, ea);
            end
            adv_cnt = 0;
         end
      end
   end

   // Driver: predicts the frame into the scoreboard, then launches it
   task automatic send(input logic [FW-1:0] f, input logic [LW-1:0] n,
                       input logic [TS_W-1:0] ts, input bit poke,
                       output logic [TS_W-1:0] t_end);
      logic [15:0]     k;
      logic [TS_W-1:0] t;
      int              nb;
      @(negedge clk);
      k  = ks;
      t  = ts + 16'd330;
      nb = (n > 32) ? 32 : int'(n);                 // R10 clamp
      for (int i = 0; i < nb; i++) begin
         logic b;
         b = f[i] ^ k[0];                           // R4
         q_t.push_back(t);        q_lvl.push_back(1'b1); q_tag.push_back(i == 0 ? 2 : 3);
         q_t.push_back(t + 16'd30); q_lvl.push_back(1'b0); q_tag.push_back(3);
         t = t + (b ? 16'd150 : 16'd90);            // R3
         k = lfsr(k);
      end
      q_t.push_back(t);          q_lvl.push_back(1'b1); q_tag.push_back(nb == 0 ? 2 : 6);
      q_t.push_back(t + 16'd30); q_lvl.push_back(1'b0); q_tag.push_back(6);
      q_done_ts.push_back(t + 16'd30);
      q_adv.push_back(nb);
      t_end = t + 16'd30;
      frame = f; len = n; ts_in = ts; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (poke) begin                               // R8: start while busy
         repeat (50) @(negedge clk);
         frame = 32'hFFFF_FFFF; len = 6'd20; ts_in = tnow; start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      while (!done) @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      logic [TS_W-1:0] te;
      repeat (4) @(negedge clk);
      // R1 reset state
      checks++;
      if (pause_out !== 1'b0 || busy !== 1'b0 || done !== 1'b0 || ks_adv !== 1'b0) begin
         errors++;
         $display("FAIL R1 reset: actual pause %0b busy %0b done %0b adv %0b, expected all 0",
                  pause_out, busy, done, ks_adv);
      end
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      send(32'h0000_00A5, 6'd8, tnow, 1'b0, te);     // R2 R3 R4 R5 R6
      send(32'hFFFF_FFFF, 6'd32, te, 1'b0, te);      // R7 chained, R11 crosses wrap
      send(32'h0, 6'd0, te, 1'b0, te);               // R9 empty frame
      send(32'h1234_5678, 6'd40, te, 1'b0, te);      // R10 clamp
      send(32'h0000_0000, 6'd5, te, 1'b1, te);       // R8 ignored start
      send(32'h0000_0001, 6'd1, tnow, 1'b0, te);     // single bit

      repeat (400) @(negedge clk);
      checks++;                                      // R8 nothing queued
      if (busy !== 1'b0 || pause_out !== 1'b0 || q_t.size() != 0) begin
         errors++;
         $display("FAIL R8 after idle: actual busy %0b pause %0b pending %0d, expected 0 0 0",
                  busy, pause_out, q_t.size());
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         errors++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule